// File: doc/BRIEF.md
# Table-Driven DAC Waveform Sequencer

The block plays a stored waveform out to a parallel digital-to-analog converter. It walks a sample table in ascending index order and wraps back to the first entry after the last one. For every sample it runs a fixed strobe sequence on the converter's control pins. First a write phase places the word on the data bus and latches it. Next a load phase starts the conversion. Last a clear phase empties the converter's input latch. A timed gap follows before the next sample, so the sample rate is set by the phase and gap parameters together.

The table holds 16-bit offset-binary codes. After reset it reads as one period of a sine wave. The default table is computed and built as read-only logic. A write port can replace any entry with an arbitrary code while the sequencer is stopped. A per-entry flag selects the written value over the default, and reset brings back the sine. A run enable starts and stops playback. When it is dropped, the sample in progress completes, including its gap. The index is kept, so the next run resumes where the last one stopped.

Top module: `wave_dac_seq`

## Requirements
- R1: While and after reset, all four strobes (`dacCsN`, `dacWrN`, `dacLoadN`, `dacClearN`) are high, `dacData` is 0 and `sampleDone` and `wrapPulse` are low until the first sample is played.
- R2: Each sample begins with a write phase of exactly PHASE_CYC cycles. In this phase `dacCsN`=0 and `dacWrN`=0 while `dacLoadN`=1 and `dacClearN`=1. `dacData` carries the table entry at the current index and does not change during the phase.
- R3: A load phase of exactly PHASE_CYC cycles follows the write phase directly. In this phase `dacLoadN`=0 and the other three strobes are 1.
- R4: A clear phase of exactly PHASE_CYC cycles follows the load phase directly. In this phase `dacClearN`=0 and the other three strobes are 1. After it, all strobes stay high for at least GAP_CYC cycles before the next write phase, and for exactly GAP_CYC cycles while `runEn` stays high.
- R5: Successive samples use indices 0, 1, …, DEPTH-1 and then 0 again.
- R6: `sampleDone` is a one-cycle pulse in the first cycle after each clear phase. `wrapPulse` is high in that same cycle exactly when the sample just finished had index DEPTH-1, and at no other time.
- R7: If `runEn` is low, no new sample starts once the current sample's gap ends, and the strobes stay high. When `runEn` is raised again, playback resumes at the index after the last sample played.
- R8: A table write (`wrEn`=1, `wrAddr` < DEPTH) takes effect only in a cycle where the sequencer is idle and `runEn` is low. A write attempted at any other time leaves the table unchanged.
- R9: Entry i of the default table is 32768 + trunc(32767·s(θ)), where θ = floor(360·i/DEPTH) degrees and s is the rational sine approximation 4x(180−x)/(40500−x(180−x)), with x taken within the half period and the sign flipped for the second half. This gives 0x8000 at 0° and 180°, 0xFFFF at 90° and 0x0001 at 270°.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Playback enable |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | ADDR_W | Table write index |
| wrData | input | DATA_W | Table write code |
| dacData | output | DATA_W | Converter data bus |
| dacCsN | output | 1 | Converter chip select, active low |
| dacWrN | output | 1 | Converter write, active low |
| dacLoadN | output | 1 | Converter load/convert strobe, active low |
| dacClearN | output | 1 | Converter latch clear, active low |
| sampleDone | output | 1 | One-cycle pulse per finished sample |
| wrapPulse | output | 1 | One-cycle pulse when the last entry finishes |

## Verification
The bench builds the block with DEPTH=8, PHASE_CYC=2 and GAP_CYC=3. With these values a full table period takes well under a hundred cycles, so the run can wrap the index twice. The run also lands on the four exact points of the default sine at indices 0, 2, 4 and 6. A two-cycle phase is the shortest length in which "holds for exactly N cycles" differs from "holds for one cycle". A three-cycle gap can be told apart from a phase length. Stopping in mid-sample, resuming at the next index, and a write attempted during playback all fall inside a few hundred cycles.

// File: rtl/wds_pkg.sv
package wds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_LOAD  = 3'd2,
    ST_CLEAR = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_t;

  // Strobes from control to datapath, valid for the coming cycle
  typedef struct packed {
    logic loadSample;  // capture table word onto the bus
    logic advance;     // last cycle of the clear phase
    logic phWrite;
    logic phLoad;
    logic phClear;
    logic tblOpen;     // table may be written this cycle
  } seq_ctl_t;

  // Default waveform code: offset-binary rational sine approximation
  function automatic logic [31:0] sineCode(input int unsigned idx,
                                           input int unsigned depth,
                                           input int unsigned width);
    longint deg, x, p, mid, mag;
    deg = (longint'(idx) * 360) / longint'(depth);
    x   = (deg >= 180) ? deg - 180 : deg;
    p   = x * (180 - x);
    mid = longint'(1) << (width - 1);
    mag = ((mid - 1) * 4 * p) / (40500 - p);
    if (deg >= 180) return 32'(mid - mag);
    else            return 32'(mid + mag);
  endfunction

endpackage

// File: rtl/wds_ctrl.sv
module wds_ctrl
  import wds_pkg::*;
#(
  parameter int PHASE_CYC = 4,
  parameter int GAP_CYC   = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  output seq_ctl_t ctl
);

  localparam int MAX_CYC = (PHASE_CYC > GAP_CYC) ? PHASE_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC) + 1;
  localparam logic [TMR_W-1:0] PH_LOAD  = TMR_W'(PHASE_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LOAD = TMR_W'(GAP_CYC - 1);

  seq_state_t state, nextState;
  logic [TMR_W-1:0] timer, nextTimer;
  logic timerDone;

  assign timerDone = (timer == '0);

  always_comb begin
    nextState = state;
    nextTimer = timerDone ? timer : timer - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (runEn) begin
          nextState = ST_WRITE;
          nextTimer = PH_LOAD;
        end
      end
      ST_WRITE: begin
        if (timerDone) begin
          nextState = ST_LOAD;
          nextTimer = PH_LOAD;
        end
      end
      ST_LOAD: begin
        if (timerDone) begin
          nextState = ST_CLEAR;
          nextTimer = PH_LOAD;
        end
      end
      ST_CLEAR: begin
        if (timerDone) begin
          nextState = ST_GAP;
          nextTimer = GAP_LOAD;
        end
      end
      ST_GAP: begin
        if (timerDone) begin
          nextState = runEn ? ST_WRITE : ST_IDLE;
          nextTimer = PH_LOAD;
        end
      end
      default: begin
        nextState = ST_IDLE;
        nextTimer = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= nextState;
      timer <= nextTimer;
    end
  end

  always_comb begin
    ctl.loadSample = (nextState == ST_WRITE) && (state != ST_WRITE);
    ctl.advance    = (state == ST_CLEAR) && timerDone;
    ctl.phWrite    = (nextState == ST_WRITE);
    ctl.phLoad     = (nextState == ST_LOAD);
    ctl.phClear    = (nextState == ST_CLEAR);
    ctl.tblOpen    = (state == ST_IDLE) && !runEn;
  end

endmodule

// File: rtl/wds_dpath.sv
module wds_dpath
  import wds_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 360,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dacData,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic              dacLoadN,
  output logic              dacClearN,
  output logic              sampleDone,
  output logic              wrapPulse
);

  localparam logic [ADDR_W:0]   DEPTH_X = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] romTab [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdVal;
  logic              wrOk;

  // Default shape as constant logic, one entry per index
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [31:0] CODE = sineCode(g, DEPTH, DATA_W);
    assign romTab[g] = CODE[DATA_W-1:0];
  end

  assign wrOk  = wrEn && ctl.tblOpen && ({1'b0, wrAddr} < DEPTH_X);
  assign rdVal = written[addr] ? ram[addr] : romTab[addr];

  always_ff @(posedge clk) begin
    if (wrOk) ram[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) written <= '0;
    else if (wrOk) written[wrAddr] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr       <= '0;
      dacData    <= '0;
      sampleDone <= 1'b0;
      wrapPulse  <= 1'b0;
    end else begin
      if (ctl.advance) addr <= (addr == LAST) ? '0 : addr + 1'b1;
      if (ctl.loadSample) dacData <= rdVal;
      sampleDone <= ctl.advance;
      wrapPulse  <= ctl.advance && (addr == LAST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCsN    <= 1'b1;
      dacWrN    <= 1'b1;
      dacLoadN  <= 1'b1;
      dacClearN <= 1'b1;
    end else begin
      dacCsN    <= !ctl.phWrite;
      dacWrN    <= !ctl.phWrite;
      dacLoadN  <= !ctl.phLoad;
      dacClearN <= !ctl.phClear;
    end
  end

endmodule

// File: rtl/wave_dac_seq.sv
module wave_dac_seq
  import wds_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 360,
  parameter int PHASE_CYC = 4,
  parameter int GAP_CYC   = 32,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dacData,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic              dacLoadN,
  output logic              dacClearN,
  output logic              sampleDone,
  output logic              wrapPulse
);

  seq_ctl_t ctl;

  wds_ctrl #(
    .PHASE_CYC(PHASE_CYC),
    .GAP_CYC  (GAP_CYC)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .runEn(runEn),
    .ctl  (ctl)
  );

  wds_dpath #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .dacData   (dacData),
    .dacCsN    (dacCsN),
    .dacWrN    (dacWrN),
    .dacLoadN  (dacLoadN),
    .dacClearN (dacClearN),
    .sampleDone(sampleDone),
    .wrapPulse (wrapPulse)
  );

endmodule

// File: rtl/wds_checker.sv
module wds_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dacData,
  input logic              dacCsN,
  input logic              dacWrN,
  input logic              dacLoadN,
  input logic              dacClearN,
  input logic              sampleDone,
  input logic              wrapPulse
);

  // R2: write and chip select move together
  a_r2_cs_with_wr: assert property (@(posedge clk) disable iff (!rstN)
    dacCsN == dacWrN);

  // R2: bus word steady for the whole write phase
  a_r2_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!dacCsN && $past(!dacCsN)) |-> $stable(dacData));

  // R4: at most one active strobe phase at a time
  a_r4_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!dacCsN, !dacLoadN, !dacClearN}) <= 1);

  // R3: load begins right after the write phase
  a_r3_load_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacLoadN) |-> $past(!dacCsN));

  // R4: clear begins right after the load phase
  a_r4_clear_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacClearN) |-> $past(!dacLoadN));

  // R2: a new write starts from all-inactive strobes
  a_r2_write_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacCsN) |-> ($past(dacClearN) && $past(dacLoadN)));

  // R6: done pulse follows the end of a clear phase
  a_r6_done_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone |-> ($rose(dacClearN) && dacCsN));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone |=> !sampleDone);

  // R6: wrap only together with done
  a_r6_wrap_with_done: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> sampleDone);

endmodule

bind wave_dac_seq wds_checker #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .dacData   (dacData),
  .dacCsN    (dacCsN),
  .dacWrN    (dacWrN),
  .dacLoadN  (dacLoadN),
  .dacClearN (dacClearN),
  .sampleDone(sampleDone),
  .wrapPulse (wrapPulse)
);

// File: tb/wave_dac_seq_tb_top.sv
module wave_dac_seq_tb_top;

  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int AW    = 3;
  localparam int PH    = 2;
  localparam int GAP   = 3;

  localparam logic [3:0] P_IDLE  = 4'b1111;
  localparam logic [3:0] P_WRITE = 4'b0011;
  localparam logic [3:0] P_LOAD  = 4'b1101;
  localparam logic [3:0] P_CLEAR = 4'b1110;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          runEn = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] dacData;
  logic dacCsN, dacWrN, dacLoadN, dacClearN, sampleDone, wrapPulse;

  wave_dac_seq #(
    .DATA_W(DW), .DEPTH(DEPTH), .PHASE_CYC(PH), .GAP_CYC(GAP), .ADDR_W(AW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .dacData(dacData), .dacCsN(dacCsN), .dacWrN(dacWrN),
    .dacLoadN(dacLoadN), .dacClearN(dacClearN), .sampleDone(sampleDone),
    .wrapPulse(wrapPulse)
  );

  typedef struct packed {
    logic [DW-1:0] data;
    logic          care;
    logic          wrap;
  } item_t;

  item_t expQ[$];
  int errors = 0;
  int checks = 0;
  int popCount = 0;
  int doneCount = 0;
  int tbIdx = 0;
  int cyc = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];
  bit known [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushSamples(input int n);
    item_t it;
    for (int i = 0; i < n; i++) begin
      it.data = model[tbIdx];
      it.care = known[tbIdx];
      it.wrap = (tbIdx == DEPTH - 1);
      expQ.push_back(it);
      tbIdx = (tbIdx + 1) % DEPTH;
    end
  endtask

  task automatic runSamples(input int n);
    int target;
    target = popCount + n;
    pushSamples(n);
    @(negedge clk);
    runEn = 1'b1;
    wait (popCount == target);
    runEn = 1'b0;
    repeat (3 * PH + GAP + 6) @(negedge clk);
  endtask

  // Monitor: pattern tracking and scoreboard
  logic [3:0] prevPat = P_IDLE;
  int  runLen = 0;
  bit  seenClear = 0;
  bit  gapAllRun = 0;
  bit  pendingWrap = 0;

  always @(negedge clk) begin
    logic [3:0] pat;
    item_t it;
    if (rstN && !finished) begin
      pat = {dacCsN, dacWrN, dacLoadN, dacClearN};
      if (pat != prevPat) begin
        check(pat == P_IDLE || pat == P_WRITE || pat == P_LOAD || pat == P_CLEAR,
              "R2", "legal strobe pattern", pat, P_IDLE);
        case (prevPat)
          P_WRITE: begin
            check(runLen == PH, "R2", "write phase length", runLen, PH);
            check(pat == P_LOAD, "R3", "load follows write", pat, P_LOAD);
          end
          P_LOAD: begin
            check(runLen == PH, "R3", "load phase length", runLen, PH);
            check(pat == P_CLEAR, "R4", "clear follows load", pat, P_CLEAR);
          end
          P_CLEAR: begin
            check(runLen == PH, "R4", "clear phase length", runLen, PH);
            check(pat == P_IDLE, "R4", "idle follows clear", pat, P_IDLE);
          end
          P_IDLE: begin
            if (seenClear) begin
              check(runLen >= GAP, "R4", "minimum gap", runLen, GAP);
              if (gapAllRun)
                check(runLen == GAP, "R4", "gap while running", runLen, GAP);
            end
          end
          default: ;
        endcase
        if (pat == P_WRITE) begin
          if (expQ.size() == 0) begin
            check(0, "R7", "sample started while stopped", popCount, -1);
          end else begin
            it = expQ.pop_front();
            if (it.care)
              check(dacData == it.data, "R5", "sample code", dacData, it.data);
            pendingWrap = it.wrap;
          end
          popCount++;
        end
        if (pat == P_IDLE && prevPat == P_CLEAR) begin
          seenClear = 1;
          gapAllRun = 1;
        end
        runLen = 1;
      end else begin
        runLen++;
      end
      if (pat == P_IDLE && !runEn) gapAllRun = 0;
      if (sampleDone) begin
        doneCount++;
        check(pat == P_IDLE && prevPat == P_CLEAR && runLen == 1, "R6",
              "done timing", pat, P_IDLE);
        check(wrapPulse == pendingWrap, "R6", "wrap flag", wrapPulse, pendingWrap);
      end else if (wrapPulse) begin
        check(0, "R6", "wrap without done", 1, 0);
      end
      prevPat = pat;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      known[i] = 0;
      model[i] = '0;
    end
    // Exact points of the default sine (R9)
    known[0] = 1; model[0] = 16'h8000;
    known[2] = 1; model[2] = 16'hFFFF;
    known[4] = 1; model[4] = 16'h8000;
    known[6] = 1; model[6] = 16'h0001;

    repeat (3) @(negedge clk);
    check({dacCsN, dacWrN, dacLoadN, dacClearN} == 4'hF, "R1",
          "strobes in reset", {dacCsN, dacWrN, dacLoadN, dacClearN}, 4'hF);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({dacCsN, dacWrN, dacLoadN, dacClearN} == 4'hF, "R1",
          "strobes after reset", {dacCsN, dacWrN, dacLoadN, dacClearN}, 4'hF);
    check(dacData == 0, "R1", "data after reset", dacData, 0);
    check(!sampleDone && !wrapPulse, "R1", "pulses after reset",
          {sampleDone, wrapPulse}, 0);

    // R9: default table at indices 0..6
    runSamples(7);

    // R7: stopped, nothing moves
    repeat (30) @(negedge clk);
    check({dacCsN, dacWrN, dacLoadN, dacClearN} == 4'hF, "R7",
          "idle strobes", {dacCsN, dacWrN, dacLoadN, dacClearN}, 4'hF);
    check(popCount == 7, "R7", "no extra samples", popCount, 7);
    check(doneCount == 7, "R6", "done count after stop", doneCount, 7);

    // R8: load a new table while idle
    for (int i = 0; i < DEPTH; i++) begin
      wrEn = 1'b1;
      wrAddr = AW'(i);
      wrData = DW'(16'h1357 + 16'h0F21 * i);
      model[i] = wrData;
      known[i] = 1;
      @(negedge clk);
    end
    wrEn = 1'b0;

    // R5/R6/R7/R8: resume at index 7, wrap twice, ignored write mid-run
    fork
      runSamples(10);
      begin
        wait (popCount == 9);
        wrEn = 1'b1;
        wrAddr = AW'(3);
        wrData = 16'hDEAD;
        @(negedge clk);
        wrEn = 1'b0;
      end
    join

    // R8: index 3 again after the run, still the old code
    runSamples(4);

    check(expQ.size() == 0, "R5", "all expected samples seen", expQ.size(), 0);
    check(doneCount == popCount, "R6", "one done per sample", doneCount, popCount);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule